// File: doc/BRIEF.md
# Line Request Coalescing Assembler

This block gathers a group of per-lane memory requests that all fall inside one cache line and folds them into a single line-wide request for the cache below. Each lane request carries an address, a byte count, a kind (read, write, atomic or instruction fetch), up to eight bytes of write data and an atomic operation code. Requests arrive one per cycle over a valid/ready handshake, and a last flag closes the group.

While a group is open, the block keeps three things. The first is a per-byte access mask over the 64-byte line. The second is a line data buffer that holds the bytes of every write. The third is a list of atomic operations, each tagged with its byte offset in the line. When the group closes, the block presents one combined request. It holds the line address, the mask, the data, the atomic list and the group's sequence number, and a flag that marks the combined request as atomic. The block holds this request until the consumer takes it, then clears its state for the next group.

Requests of the fetch kind, and requests whose bytes would run past the end of the line, are not merged. Each raises a one-cycle error pulse instead.

Top module: `line_merge_asm`

## Requirements
- R1: The combined line address is the first accepted request's address with its low 6 bits cleared. Each request's offset in the line is its address bits [5:0].
- R2: For a merged request of any kind (read 0, write 1, atomic 2), mask bits offset through offset+size-1 are set. `out_mask` bit b stands for line byte b.
- R3: A merged write places its data byte i (`in_wdata[8i+7:8i]`) at line byte offset+i (`out_data[8(offset+i)+7:8(offset+i)]`). Line bytes that no write touched read as zero.
- R4: A merged atomic leaves the data buffer unchanged. It appends {offset, op} to the atomic list in arrival order and raises `out_atom_cnt` by one. Entry k sits at `out_atom_off[6k+5:6k]` and `out_atom_op[4k+3:4k]`.
- R5: Once the combined request is taken, the mask, the data and the atomic count read zero before the next group begins.
- R6: `out_seq` is the sequence number of the group's first accepted request. `out_is_atomic` is 1 exactly when that request has the atomic kind (2).
- R7: A request of the fetch kind (3) is not merged. It raises `err_fetch` for one cycle, in the cycle after it is accepted.
- R8: When writes in one group overlap, each overlapped byte holds the data of the later request.
- R9: A non-fetch request with offset+size > 64 is not merged. It raises `err_bounds` for one cycle, in the cycle after it is accepted.
- R10: A group closes when a request with `in_last` is accepted, or at its 16th accepted request. `out_valid` rises in the next cycle and then stays high, with stable contents, until `out_ready` is seen. `in_ready` is low while `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Lane request present |
| in_ready | output | 1 | Block can accept a lane request |
| in_addr | input | 32 | Byte address of the request |
| in_size | input | 4 | Byte count, 1 to 8 |
| in_kind | input | 2 | 0 read, 1 write, 2 atomic, 3 fetch |
| in_wdata | input | 64 | Write data, byte i at bits 8i+7:8i |
| in_aop | input | 4 | Atomic operation code |
| in_seq | input | 16 | Sequence number of the group |
| in_last | input | 1 | Final request of the group |
| out_valid | output | 1 | Combined request present |
| out_ready | input | 1 | Consumer takes the combined request |
| out_line_addr | output | 32 | Line address (low 6 bits zero) |
| out_mask | output | 64 | Per-byte access mask |
| out_data | output | 512 | Line data buffer |
| out_is_atomic | output | 1 | First request of the group was atomic |
| out_seq | output | 16 | Sequence number of the group |
| out_atom_cnt | output | 5 | Number of atomic list entries |
| out_atom_off | output | 96 | Atomic entry offsets, 6 bits each |
| out_atom_op | output | 64 | Atomic entry operation codes, 4 bits each |
| err_fetch | output | 1 | Fetch request rejected (pulse) |
| err_bounds | output | 1 | Request crossing the line end rejected (pulse) |

## Verification
Several properties are checked on every cycle:
- A pending combined request holds steady while the consumer stalls, and no lane request is accepted during that time.
- Rejected fetch and out-of-range requests leave the mask untouched.
- Reads and atomics never disturb the data buffer.
- The atomic list grows by exactly one per merged atomic and never overflows.
- A merged request's mask width equals its size.
- A taken request leaves the mask cleared.

Only the bench scenarios can show the exact contents: which byte positions carry which data, the overwrite order among overlapping writes, the atomic offsets and codes, and the line address and atomic tag taken from the first request. The same holds for the closing of a group by count alone.

// File: rtl/lmq_pkg.sv
package lmq_pkg;
   typedef enum logic [1:0] {
      KIND_READ   = 2'd0,
      KIND_WRITE  = 2'd1,
      KIND_ATOMIC = 2'd2,
      KIND_FETCH  = 2'd3
   } lmq_kind_e;
endpackage

// File: rtl/lmq_lane_decode.sv
// Combinational placement of one lane request within the line.
module lmq_lane_decode #(
   parameter int LINE_BYTES = 64,
   parameter int REQ_BYTES  = 8,
   parameter int SIZE_W     = 4,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int RB_W      = $clog2(REQ_BYTES),
   localparam int EW        = OFF_W + 2
) (
   input  logic [OFF_W-1:0]        off,
   input  logic [SIZE_W-1:0]       size,
   input  logic [REQ_BYTES*8-1:0]  wdata,
   output logic                    in_range,
   output logic [LINE_BYTES-1:0]   byte_en,
   output logic [LINE_BYTES*8-1:0] line_data
);
   logic [EW-1:0] off_ext;
   logic [EW-1:0] end_pos;
   logic [7:0]    wbytes [REQ_BYTES];

   assign off_ext  = EW'(off);
   assign end_pos  = off_ext + EW'(size);
   assign in_range = (end_pos <= EW'(LINE_BYTES));

   for (genvar r = 0; r < REQ_BYTES; r++) begin : g_unpack
      assign wbytes[r] = wdata[8*r +: 8];
   end

   for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
      localparam logic [EW-1:0] POS = EW'(b);
      logic [RB_W-1:0] rel;
      assign rel           = RB_W'(b) - off[RB_W-1:0];
      assign byte_en[b]    = (POS >= off_ext) && (POS < end_pos);
      assign line_data[8*b +: 8] = byte_en[b] ? wbytes[rel] : 8'h00;
   end
endmodule

// File: rtl/lmq_line_buffer.sv
// Per-byte mask and data storage for the line being assembled.
module lmq_line_buffer #(
   parameter int LINE_BYTES = 64
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    wr_en,
   input  logic                    is_write,
   input  logic [LINE_BYTES-1:0]   byte_en,
   input  logic [LINE_BYTES*8-1:0] line_data,
   output logic [LINE_BYTES-1:0]   mask,
   output logic [LINE_BYTES*8-1:0] data
);
   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         mask <= '0;
         data <= '0;
      end else if (wr_en) begin
         for (int b = 0; b < LINE_BYTES; b++) begin
            if (byte_en[b]) begin
               mask[b] <= 1'b1;
               if (is_write) data[8*b +: 8] <= line_data[8*b +: 8];
            end
         end
      end
   end

   // R5: a cleared buffer reads empty in the next cycle
   assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (mask == '0 && data == '0));
   // R4: reads and atomics never disturb the data buffer
   assert_nowrite_keeps_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !is_write && !clr) |=> $stable(data));
endmodule

// File: rtl/lmq_atomic_list.sv
// Ordered list of offset-tagged atomic operations.
module lmq_atomic_list #(
   parameter int MAX_ENTRIES = 16,
   parameter int OFF_W       = 6,
   parameter int OP_W        = 4,
   localparam int CNT_W      = $clog2(MAX_ENTRIES + 1),
   localparam int IDX_W      = $clog2(MAX_ENTRIES)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic                         push,
   input  logic [OFF_W-1:0]             off,
   input  logic [OP_W-1:0]              op,
   output logic [CNT_W-1:0]             cnt,
   output logic [MAX_ENTRIES*OFF_W-1:0] offs,
   output logic [MAX_ENTRIES*OP_W-1:0]  ops
);
   logic [OFF_W-1:0] off_q [MAX_ENTRIES];
   logic [OP_W-1:0]  op_q  [MAX_ENTRIES];

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt <= '0;
         for (int k = 0; k < MAX_ENTRIES; k++) begin
            off_q[k] <= '0;
            op_q[k]  <= '0;
         end
      end else if (push && (cnt < CNT_W'(MAX_ENTRIES))) begin
         off_q[cnt[IDX_W-1:0]] <= off;
         op_q[cnt[IDX_W-1:0]]  <= op;
         cnt <= cnt + 1'b1;
      end
   end

   for (genvar k = 0; k < MAX_ENTRIES; k++) begin : g_pack
      assign offs[k*OFF_W +: OFF_W] = off_q[k];
      assign ops[k*OP_W +: OP_W]    = op_q[k];
   end

   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (cnt < CNT_W'(MAX_ENTRIES)));
   assert_push_counts_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !clr) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
endmodule

// File: rtl/line_merge_asm.sv
// Folds a group of same-line lane requests into one line request.
module line_merge_asm #(
   parameter int LINE_BYTES = 64,
   parameter int MAX_LANES  = 16,
   parameter int REQ_BYTES  = 8,
   parameter int ADDR_W     = 32,
   parameter int SIZE_W     = 4,
   parameter int OP_W       = 4,
   parameter int SEQ_W      = 16,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int CNT_W     = $clog2(MAX_LANES + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   output logic                       in_ready,
   input  logic [ADDR_W-1:0]          in_addr,
   input  logic [SIZE_W-1:0]          in_size,
   input  logic [1:0]                 in_kind,
   input  logic [REQ_BYTES*8-1:0]     in_wdata,
   input  logic [OP_W-1:0]            in_aop,
   input  logic [SEQ_W-1:0]           in_seq,
   input  logic                       in_last,
   output logic                       out_valid,
   input  logic                       out_ready,
   output logic [ADDR_W-1:0]          out_line_addr,
   output logic [LINE_BYTES-1:0]      out_mask,
   output logic [LINE_BYTES*8-1:0]    out_data,
   output logic                       out_is_atomic,
   output logic [SEQ_W-1:0]           out_seq,
   output logic [CNT_W-1:0]           out_atom_cnt,
   output logic [MAX_LANES*OFF_W-1:0] out_atom_off,
   output logic [MAX_LANES*OP_W-1:0]  out_atom_op,
   output logic                       err_fetch,
   output logic                       err_bounds
);
   import lmq_pkg::*;

   // Elaboration-time parameter checks
   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0 || LINE_BYTES < 4) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 4");
   end
   if ((REQ_BYTES & (REQ_BYTES - 1)) != 0 || REQ_BYTES < 2 || REQ_BYTES > LINE_BYTES) begin : g_bad_req
      $error("REQ_BYTES must be a power of two between 2 and LINE_BYTES");
   end
   if (SIZE_W > OFF_W + 1 || (1 << SIZE_W) <= REQ_BYTES) begin : g_bad_size
      $error("SIZE_W must hold REQ_BYTES and not exceed OFF_W+1");
   end
   if (ADDR_W <= OFF_W || MAX_LANES < 1) begin : g_bad_misc
      $error("ADDR_W must exceed the offset width and MAX_LANES must be positive");
   end

   lmq_kind_e                kind;
   logic                     accept, first, closing, is_fetch, merge, out_fire;
   logic                     lane_ok, lane_in_range;
   logic [LINE_BYTES-1:0]    lane_en;
   logic [LINE_BYTES*8-1:0]  lane_data;
   logic [CNT_W-1:0]         lane_cnt;
   logic [OFF_W-1:0]         lane_off;

   assign kind     = lmq_kind_e'(in_kind);
   assign lane_off = in_addr[OFF_W-1:0];
   assign in_ready = !out_valid;
   assign accept   = in_valid && in_ready;
   assign first    = (lane_cnt == '0);
   assign closing  = in_last || (lane_cnt == CNT_W'(MAX_LANES - 1));
   assign is_fetch = (kind == KIND_FETCH);
   assign lane_ok  = !is_fetch && lane_in_range;
   assign merge    = accept && lane_ok;
   assign out_fire = out_valid && out_ready;

   lmq_lane_decode #(
      .LINE_BYTES(LINE_BYTES), .REQ_BYTES(REQ_BYTES), .SIZE_W(SIZE_W)
   ) decode_i (
      .off(lane_off), .size(in_size), .wdata(in_wdata),
      .in_range(lane_in_range), .byte_en(lane_en), .line_data(lane_data)
   );

   lmq_line_buffer #(.LINE_BYTES(LINE_BYTES)) buffer_i (
      .clk(clk), .rst_n(rst_n), .clr(out_fire), .wr_en(merge),
      .is_write(kind == KIND_WRITE), .byte_en(lane_en), .line_data(lane_data),
      .mask(out_mask), .data(out_data)
   );

   lmq_atomic_list #(
      .MAX_ENTRIES(MAX_LANES), .OFF_W(OFF_W), .OP_W(OP_W)
   ) atoms_i (
      .clk(clk), .rst_n(rst_n), .clr(out_fire),
      .push(merge && (kind == KIND_ATOMIC)), .off(lane_off), .op(in_aop),
      .cnt(out_atom_cnt), .offs(out_atom_off), .ops(out_atom_op)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid     <= 1'b0;
         lane_cnt      <= '0;
         out_line_addr <= '0;
         out_seq       <= '0;
         out_is_atomic <= 1'b0;
         err_fetch     <= 1'b0;
         err_bounds    <= 1'b0;
      end else begin
         err_fetch  <= accept && is_fetch;
         err_bounds <= accept && !is_fetch && !lane_in_range;
         if (accept) begin
            if (first) begin
               out_line_addr <= {in_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
               out_seq       <= in_seq;
               out_is_atomic <= (kind == KIND_ATOMIC);
            end
            if (closing) begin
               out_valid <= 1'b1;
               lane_cnt  <= '0;
            end else begin
               lane_cnt  <= lane_cnt + 1'b1;
            end
         end else if (out_fire) begin
            out_valid <= 1'b0;
         end
      end
   end

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_mask) &&
                                     $stable(out_data) && $stable(out_seq)));
   assert_no_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);
   assert_fetch_no_merge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err_fetch |-> $stable(out_mask));
   assert_bounds_no_merge_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err_bounds |-> $stable(out_mask));
   assert_mask_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
      merge |-> ($countones(lane_en) == int'(in_size)));
   assert_first_seq_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && first) |=> (out_seq == $past(in_seq)));
endmodule

// File: tb/line_merge_asm_tb.sv
module line_merge_asm_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [31:0]  in_addr = '0;
   logic [3:0]   in_size = 4'd1;
   logic [1:0]   in_kind = 2'd0;
   logic [63:0]  in_wdata = '0;
   logic [3:0]   in_aop = '0;
   logic [15:0]  in_seq = '0;
   logic         in_last = 1'b0;
   logic         out_valid;
   logic         out_ready = 1'b0;
   logic [31:0]  out_line_addr;
   logic [63:0]  out_mask;
   logic [511:0] out_data;
   logic         out_is_atomic;
   logic [15:0]  out_seq;
   logic [4:0]   out_atom_cnt;
   logic [95:0]  out_atom_off;
   logic [63:0]  out_atom_op;
   logic         err_fetch, err_bounds;

   always #10 clk = ~clk;

   line_merge_asm dut_i (.*);

   int           checks = 0, fails = 0;
   bit           done = 1'b0;
   logic [31:0]  e_line;
   logic [15:0]  e_seq;
   logic         e_atom;
   logic [63:0]  e_mask;
   logic [511:0] e_data;
   logic [5:0]   a_off [16];
   logic [3:0]   a_op [16];
   int           a_cnt = 0, lanes = 0;

   task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_clear();
      e_mask = '0; e_data = '0; a_cnt = 0;
   endtask

   task automatic finish_group();
      int stall;
      chk("R10 out_valid after close", 512'(out_valid), 512'(1));
      chk("R10 in_ready low", 512'(in_ready), 512'(0));
      chk("R1 line address", 512'(out_line_addr), 512'(e_line));
      chk("R6 sequence", 512'(out_seq), 512'(e_seq));
      chk("R6 atomic tag", 512'(out_is_atomic), 512'(e_atom));
      chk("R2 mask", 512'(out_mask), 512'(e_mask));
      chk("R3/R8 data", out_data, e_data);
      chk("R4 atomic count", 512'(out_atom_cnt), 512'(a_cnt));
      for (int k = 0; k < a_cnt; k++) begin
         chk("R4 atomic offset", 512'(out_atom_off[6*k +: 6]), 512'(a_off[k]));
         chk("R4 atomic op", 512'(out_atom_op[4*k +: 4]), 512'(a_op[k]));
      end
      stall = $urandom % 3;
      for (int s = 0; s < stall; s++) begin
         @(negedge clk);
         chk("R10 held while stalled", {out_valid, out_mask}, {1'b1, e_mask});
      end
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      chk("R10 taken", 512'(out_valid), 512'(0));
      chk("R5 cleared", {out_mask, out_data, 59'd0, out_atom_cnt},
          {64'd0, 512'd0, 64'd0});
      model_clear();
   endtask

   task automatic send(input logic [31:0] addr, input int size, input logic [1:0] kind,
                       input logic [63:0] wd, input logic [3:0] op,
                       input logic [15:0] seq, input bit last);
      int  off;
      bit  ef, eb, closed;
      @(negedge clk);
      in_valid = 1'b1; in_addr = addr; in_size = 4'(size); in_kind = kind;
      in_wdata = wd; in_aop = op; in_seq = seq; in_last = last;
      if (lanes == 0) begin
         e_line = {addr[31:6], 6'd0}; e_seq = seq; e_atom = (kind == 2'd2);
      end
      off = int'(addr[5:0]);
      ef  = (kind == 2'd3);
      eb  = !ef && (off + size > 64);
      if (!ef && !eb) begin
         for (int i = 0; i < size; i++) begin
            e_mask[off+i] = 1'b1;
            if (kind == 2'd1) e_data[8*(off+i) +: 8] = wd[8*i +: 8];
         end
         if (kind == 2'd2) begin
            a_off[a_cnt] = 6'(off); a_op[a_cnt] = op; a_cnt++;
         end
      end
      lanes++;
      closed = last || (lanes == 16);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      chk("R7 fetch error", 512'(err_fetch), 512'(ef));
      chk("R9 bounds error", 512'(err_bounds), 512'(eb));
      if (closed) begin
         lanes = 0;
         finish_group();
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1c0a_5eed));
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 reset out_valid", 512'(out_valid), 512'(0));
      chk("R10 reset in_ready", 512'(in_ready), 512'(1));
      chk("R5 reset mask", 512'(out_mask), 512'(0));
      chk("R4 reset atom count", 512'(out_atom_cnt), 512'(0));

      // R1 R2 R3 R4: write, read, atomic in one group, write first
      send(32'h1000_0044, 4, 2'd1, 64'h0000_0000_DDCC_BBAA, 4'd0, 16'h0101, 1'b0);
      send(32'h1000_0050, 2, 2'd0, 64'h0, 4'd0, 16'h0101, 1'b0);
      send(32'h1000_0060, 4, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 4'd5, 16'h0101, 1'b1);
      // R6: atomic first tags the combined request
      send(32'h2000_0008, 8, 2'd2, 64'h0, 4'd9, 16'h0202, 1'b0);
      send(32'h2000_0000, 8, 2'd1, 64'h0807_0605_0403_0201, 4'd0, 16'h0303, 1'b1);
      // R8: overlapping writes, later wins
      send(32'h3000_0010, 8, 2'd1, 64'h1111_1111_1111_1111, 4'd0, 16'h0404, 1'b0);
      send(32'h3000_0014, 8, 2'd1, 64'h2222_2222_2222_2222, 4'd0, 16'h0404, 1'b1);
      // R9: crosses line end; R7: fetch kind
      send(32'h4000_003E, 4, 2'd1, 64'hAAAA_AAAA_AAAA_AAAA, 4'd0, 16'h0505, 1'b0);
      send(32'h4000_0000, 4, 2'd3, 64'h0, 4'd0, 16'h0505, 1'b0);
      send(32'h4000_0038, 8, 2'd1, 64'h0123_4567_89AB_CDEF, 4'd0, 16'h0505, 1'b1);
      // R10: sixteen lanes without last close the group
      for (int n = 0; n < 16; n++)
         send(32'h5000_0000 + 32'(4*n), 4, 2'd2, 64'h0, 4'(n), 16'h0606, 1'b0);

      // Random groups
      for (int g = 0; g < 400; g++) begin
         logic [31:0] base;
         int          nl;
         base = $urandom & 32'hFFFF_FFC0;
         nl   = 1 + ($urandom % 16);
         for (int l = 0; l < nl; l++) begin
            int          r;
            logic [1:0]  kd;
            r  = $urandom % 20;
            kd = (r < 8) ? 2'd1 : (r < 14) ? 2'd0 : (r < 19) ? 2'd2 : 2'd3;
            send(base | 32'($urandom % 64), 1 + ($urandom % 8), kd,
                 {$urandom, $urandom}, 4'($urandom), 16'(g), (l == nl - 1));
         end
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule